// File: doc/BRIEF.md
# DALI Forward Frame Receiver

This block decodes forward frames arriving on one serial DALI line. The line is bi-phase coded and idles high. The block brings the raw line into the clock domain and waits for a falling edge. From that edge it times each half-bit with a programmable prescaler and takes one level per half-bit by majority vote. Every pair of halves passes through a 4-bit pre-shift stage that checks its format. A pair that checks out supplies one payload bit to a 16-bit shift register.

A clean frame has a start bit, sixteen payload bits and a high stop interval. When such a frame ends, the first payload byte is loaded to the address output and the second to the data output, and an interrupt flag is set. If any check fails, the frame is dropped without a trace and the block goes back to waiting for a start edge.

The result side has no back-pressure. The flag and the two byte outputs are plain levels that software-facing logic samples. A later good frame overwrites both bytes whether or not the flag was cleared.

Top module: `dali_fwd_rx`

## Requirements
- R1: After reset, `irq_flag` is 0, `frame_addr` and `frame_data` are 0x00, and the receiver waits idle for a start edge.
- R2: One sub-tick lasts `div_n`+1 clock cycles. A half-bit lasts 16 sub-ticks, so at `div_n`=1 a half-bit is 32 clocks and at `div_n`=3 it is 64 clocks. Frames timed this way decode correctly at either setting.
- R3: Coding is as follows. A logical 1 is a low half followed by a high half, and a logical 0 is a high half followed by a low half. A frame opens with a start bit of value 1, and a start bit whose second half is not high discards the frame.
- R4: Payload bits arrive most significant first. Bits 15..8 go to `frame_addr` and bits 7..0 go to `frame_data`.
- R5: The four half-bits after the last payload bit must all be high. If any of them is low, the frame is discarded.
- R6: A pair of halves with no mid-bit transition discards the frame. After a discard, `frame_addr`, `frame_data` and `irq_flag` keep their values.
- R7: After a discarded frame, the next correctly formed frame is received normally.
- R8: A good frame sets `irq_flag`. The flag stays at 1 until `irq_clr` is asserted.
- R9: When `irq_clr` is high in the same cycle that a frame completes, `irq_flag` stays 0, but the two bytes are still loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | 8 | Prescaler value N; one sub-tick every N+1 clocks |
| rx_line | input | 1 | Raw DALI line, idles high |
| irq_clr | input | 1 | Clears the interrupt flag; wins over a simultaneous set |
| frame_addr | output | 8 | First received payload byte |
| frame_data | output | 8 | Second received payload byte |
| irq_flag | output | 1 | Set by a good frame, sticky until cleared |

## Verification
Two events can land on the same clock edge: a frame completing, which sets the flag, and a clear request. To force the collision, the bench holds `irq_clr` high through the whole of one frame and for some cycles after it. It then watches the flag on every cycle: the flag must never read 1, yet both byte outputs must show the new frame. For all other frames, a monitor clears the flag only after checking that it stayed set, so the sticky behaviour and the priority of the clear are each judged separately.

// File: rtl/dali_rx_pkg.sv
package dali_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam int SUBS_PER_HALF = 16;
  localparam int PAYLOAD_BITS  = 16;
  localparam int STOP_HALVES   = 4;
endpackage

// File: rtl/dali_rx_prescale.sv
module dali_rx_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div_n != '0) |=> (!tick || !$stable(div_n))); // R2
endmodule

// File: rtl/dali_rx_halfbit.sv
module dali_rx_halfbit #(
  parameter int SUBS = dali_rx_pkg::SUBS_PER_HALF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic tick,
  input  logic line_s,
  output logic half_done,
  output logic half_lvl
);
  localparam int SW      = $clog2(SUBS);
  localparam int VOTE_LO = SUBS/2 - 2;
  localparam int VOTE_HI = SUBS/2;

  logic [SW-1:0] sub_q;
  logic [1:0]    votes_q;
  logic          in_window;

  assign in_window = (int'(sub_q) >= VOTE_LO) && (int'(sub_q) <= VOTE_HI);
  assign half_done = active && tick && (int'(sub_q) == SUBS-1);
  assign half_lvl  = (votes_q >= 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      votes_q <= '0;
    end else if (restart) begin
      sub_q   <= '0;
      votes_q <= '0;
    end else if (active && tick) begin
      sub_q <= sub_q + 1'b1;
      if (half_done)
        votes_q <= '0;
      else if (in_window && line_s)
        votes_q <= votes_q + 1'b1;
    end
  end
endmodule

// File: rtl/dali_rx_decode.sv
module dali_rx_decode
  import dali_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_s,
  input  logic        half_done,
  input  logic        half_lvl,
  output logic        arm,
  output logic        active,
  output logic        frame_ok,
  output logic [PAYLOAD_BITS-1:0] frame_word
);
  localparam int DATA_HALVES = 2*PAYLOAD_BITS;
  localparam int HW = $clog2(DATA_HALVES + 1);

  rx_state_e         st_q;
  logic [3:0]        pre_q;
  logic [HW-1:0]     hcnt_q;
  logic [PAYLOAD_BITS-1:0] sr_q;
  logic              line_d;
  logic              second_half;
  logic              stop_last;

  assign arm         = (st_q == ST_IDLE) && line_d && !line_s;
  assign active      = (st_q != ST_IDLE);
  assign second_half = hcnt_q[0];
  assign stop_last   = (st_q == ST_STOP) && (int'(hcnt_q) == STOP_HALVES-1);
  assign frame_ok    = half_done && stop_last && ({pre_q[2:0], half_lvl} == 4'hF);
  assign frame_word  = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pre_q  <= 4'hF;
      hcnt_q <= '0;
      sr_q   <= '0;
      line_d <= 1'b1;
    end else begin
      line_d <= line_s;
      if (arm) begin
        st_q   <= ST_START;
        hcnt_q <= '0;
      end else if (half_done) begin
        pre_q  <= {pre_q[2:0], half_lvl};
        hcnt_q <= hcnt_q + 1'b1;
        unique case (st_q)
          ST_START: if (second_half) begin
            if ({pre_q[0], half_lvl} == 2'b01) begin
              st_q   <= ST_DATA;
              hcnt_q <= '0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_DATA: if (second_half) begin
            if (pre_q[0] == half_lvl) begin
              st_q <= ST_IDLE;
            end else begin
              sr_q <= {sr_q[PAYLOAD_BITS-2:0], half_lvl};
              if (int'(hcnt_q) == DATA_HALVES-1) begin
                st_q   <= ST_STOP;
                hcnt_q <= '0;
              end
            end
          end
          ST_STOP: if (stop_last) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_START_WAS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && hcnt_q == '0) |-> pre_q[0]); // R3
  AST_OK_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !active); // R5
endmodule

// File: rtl/dali_fwd_rx.sv
module dali_fwd_rx
  import dali_rx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             rx_line,
  input  logic             irq_clr,
  output logic [7:0]       frame_addr,
  output logic [7:0]       frame_data,
  output logic             irq_flag
);
  logic [1:0] sync_q;
  logic       line_s, tick, arm, active, half_done, half_lvl, frame_ok;
  logic [PAYLOAD_BITS-1:0] word;

  assign line_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};
  end

  dali_rx_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(arm), .div_n(div_n), .tick(tick));

  dali_rx_halfbit #(.SUBS(SUBS_PER_HALF)) u_half (
    .clk(clk), .rst_n(rst_n), .restart(arm), .active(active), .tick(tick),
    .line_s(line_s), .half_done(half_done), .half_lvl(half_lvl));

  dali_rx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .half_done(half_done),
    .half_lvl(half_lvl), .arm(arm), .active(active), .frame_ok(frame_ok),
    .frame_word(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_addr <= '0;
      frame_data <= '0;
      irq_flag   <= 1'b0;
    end else begin
      if (frame_ok) begin
        frame_addr <= word[PAYLOAD_BITS-1 -: 8];
        frame_data <= word[7:0];
      end
      if (irq_clr)       irq_flag <= 1'b0;
      else if (frame_ok) irq_flag <= 1'b1;
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R8
  AST_NO_LOAD_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> ($stable(frame_addr) && $stable(frame_data))); // R6
endmodule

// File: tb/dali_fwd_rx_tb.sv
module dali_fwd_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_n = 8'd1;
  logic       rx_line = 1'b1;
  logic       clr_drv = 1'b0;
  logic       clr_mon = 1'b0;
  logic [7:0] frame_addr, frame_data;
  logic       irq_flag;
  int         checks = 0;
  int         errors = 0;
  int         half_clks = 32;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  dali_fwd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .rx_line(rx_line),
    .irq_clr(clr_drv | clr_mon), .frame_addr(frame_addr),
    .frame_data(frame_data), .irq_flag(irq_flag));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hb(input logic lvl);
    rx_line = lvl;
    repeat (half_clks) @(negedge clk);
  endtask

  // kind: 0 good, 1 bad start, 2 no transition in bit 9, 3 low stop half
  task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input int kind);
    logic [15:0] w;
    w = {a, d};
    if (kind == 0) exp_q.push_back(w);
    hb(1'b0);
    if (kind == 1) begin
      hb(1'b0);
    end else begin
      hb(1'b1);
      for (int i = 15; i >= 0; i--) begin
        if (kind == 2 && i == 9) begin
          hb(1'b1); hb(1'b1);
        end else begin
          hb(~w[i]); hb(w[i]);
        end
      end
      hb(kind == 3 ? 1'b0 : 1'b1);
      hb(1'b1); hb(1'b1); hb(1'b1);
    end
    for (int k = 0; k < 6; k++) hb(1'b1);
  endtask

  // monitor: pop expected word when flag is seen, verify stickiness, then clear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && irq_flag && !clr_mon && !clr_drv) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected frame flag", 16'd1, 16'd0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk("R4 address byte", {8'h0, frame_addr}, {8'h0, e[15:8]});
          chk("R4 data byte", {8'h0, frame_data}, {8'h0, e[7:0]});
          repeat (5) @(negedge clk);
          chk("R8 flag sticky", {15'h0, irq_flag}, 16'd1);
        end
        clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0;
        @(negedge clk);
        chk("R8 flag cleared", {15'h0, irq_flag}, 16'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 flag after reset", {15'h0, irq_flag}, 16'd0);
    chk("R1 outputs after reset", {frame_addr, frame_data}, 16'h0000);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 R3 R4 R8: several patterns at div_n=1
    send_frame(8'hA5, 8'h3C, 0);
    send_frame(8'h00, 8'hFF, 0);
    send_frame(8'hFF, 8'h00, 0);
    send_frame(8'h80, 8'h01, 0);

    // R3: start bit second half low
    send_frame(8'h11, 8'h22, 1);
    chk("R3 bad start dropped", {frame_addr, frame_data}, 16'h8001);
    // R6: missing mid-bit transition
    send_frame(8'h33, 8'h44, 2);
    chk("R6 bad bit dropped", {frame_addr, frame_data}, 16'h8001);
    chk("R6 flag untouched", {15'h0, irq_flag}, 16'd0);
    // R5: low stop half
    send_frame(8'h55, 8'h66, 3);
    chk("R5 bad stop dropped", {frame_addr, frame_data}, 16'h8001);
    // R7: good frame after discards
    send_frame(8'h12, 8'h34, 0);

    // R2: slower prescaler
    div_n = 8'd3;
    half_clks = 64;
    send_frame(8'h5A, 8'hC3, 0);
    div_n = 8'd1;
    half_clks = 32;

    // R9: clear held across frame completion
    clr_drv = 1'b1;
    fork
      send_frame(8'h77, 8'hEE, 1);
      begin
        int seen;
        seen = 0;
        for (int c = 0; c < 40 * 32; c++) begin
          @(negedge clk);
          if (irq_flag) seen = 1;
        end
        chk("R9 flag held low by clear", seen[15:0], 16'd0);
      end
    join
    // kind 1 above drops; now the real collision frame
    fork
      begin
        logic [15:0] w;
        w = 16'h77EE;
        hb(1'b0); hb(1'b1);
        for (int i = 15; i >= 0; i--) begin hb(~w[i]); hb(w[i]); end
        for (int k = 0; k < 8; k++) hb(1'b1);
      end
      begin
        int seen;
        seen = 0;
        for (int c = 0; c < 44 * 32; c++) begin
          @(negedge clk);
          if (irq_flag) seen = 1;
        end
        chk("R9 flag never set under clear", seen[15:0], 16'd0);
      end
    join
    chk("R9 bytes still loaded", {frame_addr, frame_data}, 16'h77EE);
    clr_drv = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 flag stays low after clear released", {15'h0, irq_flag}, 16'd0);

    repeat (50) @(negedge clk);
    chk("R4 all expected frames seen", exp_q.size(), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule